// File: doc/BRIEF.md
# Serial Real-Time-Clock Slave

This block is the device side of a small serial real-time clock. A host selects it, toggles a serial clock and moves bits on a data-in line. The block returns bits on a data-out line. Every transaction is sixteen falling serial-clock edges long. The first eight edges carry a command byte. The last eight carry one data byte, which flows toward the device on a write and toward the host on a read.

The command byte picks the target. One command range reaches a 32-byte battery-backed RAM. One range reads calendar fields in packed BCD. Two codes read the status and control registers. One write code clears the power-fail flags in status and drops the power-interrupt output. A one-second tick input advances the calendar, which keeps month lengths and leap years.

All logic runs on the system clock. The serial clock and data lines are sampled on that clock, so a serial-clock level must be held for at least one system-clock cycle.

Top module: `rtc_serial_slave`

## Requirements
- R1: After reset, status holds the STATUS_RST parameter and control holds CTRL_RST. `pwrIrq` is high and `sdo` is low.
- R2: While `sel` is high, each falling edge of `sclk` samples `sdi`. The first eight edges shift the command in MSB first. Commands 0x80–0x9F and 0xB1 are writes. Every other command is a read.
- R3: A write with command 0x80+n stores the data byte in RAM word n once the sixteenth edge has arrived. A read with command n (0x00–0x1F) returns that word.
- R4: The read commands return these BCD fields: 0x20 seconds, 0x21 minutes, 0x22 hours, 0x24 day of month, 0x25 month (1–12), 0x26 two-digit year.
- R5: Reads of codes 0x20–0x2F that are not listed in R4 return 0x00. So do reads of codes that do not map to RAM, calendar, status or control.
- R6: In a read, `sdo` carries the return byte MSB first. Bit 7 appears after the eighth falling edge, and each later falling edge moves to the next lower bit. At all other times `sdo` is 0.
- R7: A write with command 0xB1 and data bit 2 set clears status bits 3 and 4 and drives `pwrIrq` low. With bit 2 clear, the write changes neither status nor `pwrIrq`.
- R8: Deasserting `sel` aborts the transaction. A write cut short before its sixteenth edge leaves RAM unchanged.
- R9: Falling edges after the sixteenth are ignored until `sel` next drops. They cause no second write, and `sdo` stays low.
- R10: Each cycle with `secTick` high advances the seconds. Seconds and minutes wrap from 59 to 00, and hours wrap from 23 to 00. Each wrap carries into the next field.
- R11: The day of month wraps to 01 after the last day of the month. February has 29 days when the year is divisible by 4. Month wraps 12→01, and year wraps 99→00.
- R12: Read command 0x30 returns status and 0x31 returns control.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Device select, active high |
| sclk | input | 1 | Host serial clock |
| sdi | input | 1 | Serial data from host |
| secTick | input | 1 | One-second advance, one step per cycle high |
| sdo | output | 1 | Serial data to host |
| pwrIrq | output | 1 | Power-fail interrupt, active high |

## Verification
Instance u0 is built with status reset 0x1C and control reset 0xA5. These values make the bit-clearing write on 0xB1 visible in the status readback, and they make the control readback distinct from zero. Its calendar starts at year 99, 31 December, 23:59:50, so a few ticks reach every rollover from seconds through year. A second instance, u1, starts at 28 February 23:59:59 in year 24. This start brings the leap day and the following 1 March within about 86,400 ticks.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int TXN_EDGES = 16;
  localparam int PH_W      = $clog2(TXN_EDGES + 1);
  localparam int RAM_WORDS = 32;
  localparam int RAM_AW    = $clog2(RAM_WORDS);

  localparam logic [7:0] CMD_STATUS_RD = 8'h30;
  localparam logic [7:0] CMD_CTRL_RD   = 8'h31;
  localparam logic [7:0] CMD_STATUS_WR = 8'hB1;
  localparam logic [7:0] CMD_RAM_WR    = 8'h80;

  typedef struct packed {
    logic        latchRead;
    logic [7:0]  nextCmd;
    logic        shiftVal;
    logic        drive;
    logic [2:0]  bitSel;
    logic        commit;
    logic        clear;
    logic [7:0]  cmd;
  } strobeT;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] day;
    logic [7:0] mon;
    logic [7:0] year;
  } timeT;

  function automatic logic isWrite(input logic [7:0] c);
    return (c[7:5] == 3'b100) || (c == CMD_STATUS_WR);
  endfunction

endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   sel,
  input  logic   sclk,
  input  logic   sdi,
  output strobeT strb
);

  logic            sclkD;
  logic [PH_W-1:0] phase;
  logic [7:0]      cmd;
  logic            commitQ;
  logic            fall;
  logic [7:0]      nextCmd;
  logic            done;

  assign fall    = sclkD & ~sclk;
  assign nextCmd = {cmd[6:0], sdi};
  assign done    = (phase == PH_W'(TXN_EDGES));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkD   <= 1'b0;
      phase   <= '0;
      cmd     <= '0;
      commitQ <= 1'b0;
    end else begin
      sclkD   <= sclk;
      commitQ <= sel && fall && (phase == PH_W'(TXN_EDGES - 1)) && isWrite(cmd);
      if (!sel) begin
        phase <= '0;
        cmd   <= '0;
      end else if (fall && !done) begin
        phase <= phase + 1'b1;
        if (phase < PH_W'(8)) cmd <= nextCmd;
      end
    end
  end

  always_comb begin
    strb           = '0;
    strb.nextCmd   = nextCmd;
    strb.cmd       = cmd;
    strb.clear     = !sel;
    strb.latchRead = sel && fall && (phase == PH_W'(7)) && !isWrite(nextCmd);
    strb.shiftVal  = sel && fall && (phase >= PH_W'(8)) && !done && isWrite(cmd);
    strb.drive     = sel && (phase >= PH_W'(8)) && !done && !isWrite(cmd);
    strb.bitSel    = ~phase[2:0];
    strb.commit    = commitQ && sel;
  end

  a_r9_phase_cap: assert property (@(posedge clk) disable iff (!rstN)
    phase <= PH_W'(TXN_EDGES));

  a_r8_desel_clears: assert property (@(posedge clk) disable iff (!rstN)
    !sel |=> (phase == '0) && (cmd == '0));

  a_r2_phase_step: assert property (@(posedge clk) disable iff (!rstN)
    (sel && fall && !done) |=> (phase == $past(phase) + 1'b1));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter logic [7:0] INIT_SEC  = 8'h00,
  parameter logic [7:0] INIT_MIN  = 8'h00,
  parameter logic [7:0] INIT_HOUR = 8'h00,
  parameter logic [7:0] INIT_DAY  = 8'h01,
  parameter logic [7:0] INIT_MON  = 8'h01,
  parameter logic [7:0] INIT_YEAR = 8'h00
)(
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  output timeT now
);

  timeT       cur;
  logic [6:0] yearBin;
  logic       leap;
  logic [7:0] lastDay;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  assign yearBin = 7'(cur.year[7:4]) * 7'd10 + 7'(cur.year[3:0]);
  assign leap    = (yearBin[1:0] == 2'b00);

  always_comb begin
    case (cur.mon)
      8'h02:                      lastDay = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: lastDay = 8'h30;
      default:                    lastDay = 8'h31;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cur <= '{sec: INIT_SEC, min: INIT_MIN, hour: INIT_HOUR,
               day: INIT_DAY, mon: INIT_MON, year: INIT_YEAR};
    end else if (tick) begin
      cur.sec <= (cur.sec == 8'h59) ? 8'h00 : bcdInc(cur.sec);
      if (cur.sec == 8'h59) begin
        cur.min <= (cur.min == 8'h59) ? 8'h00 : bcdInc(cur.min);
        if (cur.min == 8'h59) begin
          cur.hour <= (cur.hour == 8'h23) ? 8'h00 : bcdInc(cur.hour);
          if (cur.hour == 8'h23) begin
            cur.day <= (cur.day == lastDay) ? 8'h01 : bcdInc(cur.day);
            if (cur.day == lastDay) begin
              cur.mon <= (cur.mon == 8'h12) ? 8'h01 : bcdInc(cur.mon);
              if (cur.mon == 8'h12)
                cur.year <= (cur.year == 8'h99) ? 8'h00 : bcdInc(cur.year);
            end
          end
        end
      end
    end
  end

  assign now = cur;

  a_r10_time_range: assert property (@(posedge clk) disable iff (!rstN)
    (cur.sec <= 8'h59) && (cur.sec[3:0] <= 4'd9) &&
    (cur.min <= 8'h59) && (cur.min[3:0] <= 4'd9) && (cur.hour <= 8'h23));

  a_r11_date_range: assert property (@(posedge clk) disable iff (!rstN)
    (cur.day >= 8'h01) && (cur.day <= 8'h31) &&
    (cur.mon >= 8'h01) && (cur.mon <= 8'h12));

  a_r10_tick_moves: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> (cur.sec != $past(cur.sec)));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(cur));

endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter logic [7:0] STATUS_RST = 8'h00,
  parameter logic [7:0] CTRL_RST   = 8'h00
)(
  input  logic   clk,
  input  logic   rstN,
  input  logic   sdi,
  input  strobeT strb,
  input  timeT   now,
  output logic   sdo,
  output logic   pwrIrq
);

  logic [7:0] ram [RAM_WORDS];
  logic [7:0] status;
  logic [7:0] control;
  logic [7:0] val;
  logic [7:0] ret;
  logic [7:0] lookup;

  always_comb begin
    lookup = 8'h00;
    if (strb.nextCmd[7:5] == 3'b000) begin
      lookup = ram[strb.nextCmd[RAM_AW-1:0]];
    end else begin
      case (strb.nextCmd)
        8'h20:         lookup = now.sec;
        8'h21:         lookup = now.min;
        8'h22:         lookup = now.hour;
        8'h24:         lookup = now.day;
        8'h25:         lookup = now.mon;
        8'h26:         lookup = now.year;
        CMD_STATUS_RD: lookup = status;
        CMD_CTRL_RD:   lookup = control;
        default:       lookup = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (strb.commit && (strb.cmd[7:5] == CMD_RAM_WR[7:5]))
      ram[strb.cmd[RAM_AW-1:0]] <= val;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status  <= STATUS_RST;
      control <= CTRL_RST;
      pwrIrq  <= 1'b1;
      val     <= '0;
      ret     <= '0;
    end else begin
      if (strb.clear)          val <= '0;
      else if (strb.shiftVal)  val <= {val[6:0], sdi};
      if (strb.latchRead)      ret <= lookup;
      if (strb.commit && (strb.cmd == CMD_STATUS_WR) && val[2]) begin
        status <= status & ~8'h18;
        pwrIrq <= 1'b0;
      end
    end
  end

  assign sdo = strb.drive & ret[strb.bitSel];

  a_r7_irq_no_rise: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(pwrIrq));

  a_r7_irq_status: assert property (@(posedge clk) disable iff (!rstN)
    !pwrIrq |-> ((status & 8'h18) == 8'h00));

  a_r12_ctrl_fixed: assert property (@(posedge clk) disable iff (!rstN)
    $stable(control));

endmodule

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave
  import rtc_pkg::*;
#(
  parameter logic [7:0] STATUS_RST = 8'h00,
  parameter logic [7:0] CTRL_RST   = 8'h00,
  parameter logic [7:0] INIT_SEC   = 8'h00,
  parameter logic [7:0] INIT_MIN   = 8'h00,
  parameter logic [7:0] INIT_HOUR  = 8'h00,
  parameter logic [7:0] INIT_DAY   = 8'h01,
  parameter logic [7:0] INIT_MON   = 8'h01,
  parameter logic [7:0] INIT_YEAR  = 8'h00
)(
  input  logic clk,
  input  logic rstN,
  input  logic sel,
  input  logic sclk,
  input  logic sdi,
  input  logic secTick,
  output logic sdo,
  output logic pwrIrq
);

  strobeT strb;
  timeT   now;

  rtc_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .sel  (sel),
    .sclk (sclk),
    .sdi  (sdi),
    .strb (strb)
  );

  rtc_calendar #(
    .INIT_SEC (INIT_SEC),  .INIT_MIN (INIT_MIN), .INIT_HOUR (INIT_HOUR),
    .INIT_DAY (INIT_DAY),  .INIT_MON (INIT_MON), .INIT_YEAR (INIT_YEAR)
  ) u_cal (
    .clk  (clk),
    .rstN (rstN),
    .tick (secTick),
    .now  (now)
  );

  rtc_datapath #(
    .STATUS_RST (STATUS_RST),
    .CTRL_RST   (CTRL_RST)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .sdi    (sdi),
    .strb   (strb),
    .now    (now),
    .sdo    (sdo),
    .pwrIrq (pwrIrq)
  );

endmodule

// File: tb/sim_rtc_serial_slave.sv
module sim_rtc_serial_slave;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sel0 = 1'b0, sel1 = 1'b0;
  logic tick0 = 1'b0, tick1 = 1'b0;
  logic sdo0, sdo1, irq0, irq1;
  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;

  always #4 clk = ~clk;

  rtc_serial_slave #(
    .STATUS_RST (8'h1C), .CTRL_RST (8'hA5),
    .INIT_SEC (8'h50), .INIT_MIN (8'h59), .INIT_HOUR (8'h23),
    .INIT_DAY (8'h31), .INIT_MON (8'h12), .INIT_YEAR (8'h99)
  ) u0 (
    .clk (clk), .rstN (rstN), .sel (sel0), .sclk (sclk), .sdi (sdi),
    .secTick (tick0), .sdo (sdo0), .pwrIrq (irq0)
  );

  rtc_serial_slave #(
    .INIT_SEC (8'h59), .INIT_MIN (8'h59), .INIT_HOUR (8'h23),
    .INIT_DAY (8'h28), .INIT_MON (8'h02), .INIT_YEAR (8'h24)
  ) u1 (
    .clk (clk), .rstN (rstN), .sel (sel1), .sclk (sclk), .sdi (sdi),
    .secTick (tick1), .sdo (sdo1), .pwrIrq (irq1)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Runs one transaction of 'edges' falling edges; samples sdo before each edge.
  task automatic xfer(input bit dev, input logic [7:0] cmd, input logic [7:0] dat,
                      input int edges, output logic [7:0] rd, output int quietBad);
    logic [15:0] bits;
    bits = {cmd, dat};
    rd = '0;
    quietBad = 0;
    @(negedge clk);
    if (dev) sel1 = 1'b1; else sel0 = 1'b1;
    for (int i = 0; i < edges; i++) begin
      @(negedge clk);
      sdi  = (i < 16) ? bits[15-i] : 1'b1;
      sclk = 1'b1;
      if (i >= 8 && i < 16) rd[15-i] = dev ? sdo1 : sdo0;
      else if ((dev ? sdo1 : sdo0) !== 1'b0) quietBad++;
      @(negedge clk);
      @(negedge clk);
      sclk = 1'b0;
      @(negedge clk);
    end
    @(negedge clk);
    if ((dev ? sdo1 : sdo0) !== 1'b0) quietBad++;
    @(negedge clk);
    sel0 = 1'b0;
    sel1 = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd8(input bit dev, input logic [7:0] cmd, output logic [7:0] v);
    int q;
    xfer(dev, cmd, 8'h00, 16, v, q);
    check("R6 sdo quiet outside data bits", 8'(q), 8'h00);
  endtask

  task automatic wr8(input bit dev, input logic [7:0] cmd, input logic [7:0] d);
    logic [7:0] v;
    int q;
    xfer(dev, cmd, d, 16, v, q);
  endtask

  task automatic ticks(input bit dev, input int n);
    @(negedge clk);
    if (dev) tick1 = 1'b1; else tick0 = 1'b1;
    repeat (n) @(negedge clk);
    tick0 = 1'b0;
    tick1 = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 pwrIrq after reset", {7'd0, irq0}, 8'h01);
    check("R1 sdo after reset", {7'd0, sdo0}, 8'h00);
    rd8(0, 8'h30, v); check("R12 R1 status read", v, 8'h1C);
    rd8(0, 8'h31, v); check("R12 R1 control read", v, 8'hA5);
  endtask

  task automatic t_ram;
    logic [7:0] v;
    wr8(0, 8'h80, 8'h5A);
    wr8(0, 8'h9F, 8'hC3);
    wr8(0, 8'h87, 8'h81);
    rd8(0, 8'h00, v); check("R3 R2 RAM word 0", v, 8'h5A);
    rd8(0, 8'h1F, v); check("R3 RAM word 31", v, 8'hC3);
    rd8(0, 8'h07, v); check("R3 R6 RAM word 7 MSB first", v, 8'h81);
  endtask

  task automatic t_time;
    logic [7:0] v;
    rd8(0, 8'h20, v); check("R4 seconds", v, 8'h50);
    rd8(0, 8'h21, v); check("R4 minutes", v, 8'h59);
    rd8(0, 8'h22, v); check("R4 hours", v, 8'h23);
    rd8(0, 8'h24, v); check("R4 day", v, 8'h31);
    rd8(0, 8'h25, v); check("R4 month", v, 8'h12);
    rd8(0, 8'h26, v); check("R4 year", v, 8'h99);
  endtask

  task automatic t_unused;
    logic [7:0] v;
    rd8(0, 8'h23, v); check("R5 code 0x23", v, 8'h00);
    rd8(0, 8'h2F, v); check("R5 code 0x2F", v, 8'h00);
    rd8(0, 8'h40, v); check("R5 code 0x40", v, 8'h00);
    rd8(0, 8'hFF, v); check("R5 R2 code 0xFF is a read", v, 8'h00);
  endtask

  task automatic t_abort;
    logic [7:0] v;
    int q;
    wr8(0, 8'h85, 8'h11);
    xfer(0, 8'h85, 8'hEE, 12, v, q);
    rd8(0, 8'h05, v); check("R8 aborted write leaves RAM", v, 8'h11);
  endtask

  task automatic t_extra;
    logic [7:0] v;
    int q;
    xfer(0, 8'h86, 8'h3C, 24, v, q);
    rd8(0, 8'h06, v); check("R9 extra edges ignored on write", v, 8'h3C);
    xfer(0, 8'h06, 8'h00, 24, v, q);
    check("R9 read value with extra edges", v, 8'h3C);
    check("R9 R6 sdo low after edge 16", 8'(q), 8'h00);
  endtask

  task automatic t_status;
    logic [7:0] v;
    wr8(0, 8'hB1, 8'hFB);
    rd8(0, 8'h30, v); check("R7 status kept without bit 2", v, 8'h1C);
    check("R7 pwrIrq kept without bit 2", {7'd0, irq0}, 8'h01);
    wr8(0, 8'hB1, 8'h04);
    rd8(0, 8'h30, v); check("R7 status bits 3 4 cleared", v, 8'h04);
    check("R7 pwrIrq dropped", {7'd0, irq0}, 8'h00);
  endtask

  task automatic t_roll;
    logic [7:0] v;
    ticks(0, 9);
    rd8(0, 8'h20, v); check("R10 seconds before wrap", v, 8'h59);
    ticks(0, 1);
    rd8(0, 8'h20, v); check("R10 seconds wrap", v, 8'h00);
    rd8(0, 8'h21, v); check("R10 minutes wrap", v, 8'h00);
    rd8(0, 8'h22, v); check("R10 hours wrap", v, 8'h00);
    rd8(0, 8'h24, v); check("R11 day wrap", v, 8'h01);
    rd8(0, 8'h25, v); check("R11 month wrap", v, 8'h01);
    rd8(0, 8'h26, v); check("R11 year wrap", v, 8'h00);
    ticks(0, 61);
    rd8(0, 8'h21, v); check("R10 minute carry", v, 8'h01);
    rd8(0, 8'h20, v); check("R10 seconds after carry", v, 8'h01);
  endtask

  task automatic t_leap;
    logic [7:0] v;
    ticks(1, 1);
    rd8(1, 8'h24, v); check("R11 leap day", v, 8'h29);
    rd8(1, 8'h25, v); check("R11 leap month", v, 8'h02);
    ticks(1, 86400);
    rd8(1, 8'h24, v); check("R11 day after leap", v, 8'h01);
    rd8(1, 8'h25, v); check("R11 month after leap", v, 8'h03);
    rd8(1, 8'h22, v); check("R10 hour after day", v, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_ram();
    t_time();
    t_unused();
    t_abort();
    t_extra();
    t_status();
    t_roll();
    t_leap();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule